// File: doc/BRIEF.md
# I2C Master Bit-Rate Generator

This block turns the oscillator clock into the serial clock timing that an I2C master needs. A three-bit rate code picks the period of the generated clock. Seven codes pick a fixed divisor of the oscillator: 60, 120, 160, 192, 224, 256 or 960. The remaining code takes the rate from an internal 8-bit auto-reload timer. That timer counts oscillator cycles from a programmable reload value up to its top and then reloads. One serial clock period lasts 96 of its overflows.

The generator produces a square-wave clock with a 50% duty cycle. It also produces a one-cycle tick at the start of every period, which the master's sequencing logic can use as a timing reference. While the enable input is low, the output clock rests high and all counting is held. A new rate code is latched only at the start of a period, so a period that has already begun always finishes at its old length.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: With rate code 0, 1, 2 or 3 on `rate_i`, the period of `scl_o` (rising edge to rising edge) is 256, 224, 192 or 160 clock cycles respectively.
- R2: With rate code 4, 5 or 6 on `rate_i`, the period of `scl_o` is 960, 120 or 60 clock cycles respectively.
- R3: With rate code 7 on `rate_i`, the internal 8-bit timer counts up one step per clock from `reload_i` and reloads `reload_i` after it reaches 255. The period of `scl_o` is 96 × (256 − `reload_i`) clock cycles.
- R4: In every period, `scl_o` is high for exactly half of the period and low for the other half.
- R5: From the clock edge after `en_i` is sampled low, and while reset is held, `scl_o` is 1 and `tick_o` is 0. Both stay that way for as long as `en_i` stays low.
- R6: A change on `rate_i` takes effect at the next rising edge of `scl_o`. The period in progress completes with the divisor it started with.
- R7: `tick_o` is high for one cycle in exactly those cycles in which `scl_o` has just risen. It is never high on the edge that first samples `en_i` high.
- R8: After `en_i` goes high, `scl_o` first falls half a divisor of clock cycles after the first edge that samples it high. With code 3 this is on the 81st rising edge counted from that first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Generator enable (master operation) |
| rate_i | input | 3 | Rate code: bit 2 is the high rate bit, bits 1..0 are the low rate bits |
| reload_i | input | 8 | Reload value of the auto-reload timer used by code 7 |
| scl_o | output | 1 | Generated serial clock, idle high |
| tick_o | output | 1 | One-cycle pulse at each rising edge of `scl_o` |

## Verification
The hardest case to reach from the ports is a rate change that lands in the middle of a period. To prove the old divisor still governs that period, the stimulus has to wait for a period start and then change the code a few cycles into the high phase. The scoreboard then expects one more period of the old length before the new one.

Timer-driven periods are long and depend on how the timer phase lines up with the period start. For that reason the generator is disabled and re-enabled for each reload value, which restarts the timer from `reload_i`. The first period after every enable is used only to align the monitor, so every period that is compared starts on a known boundary.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

  typedef logic [2:0] rate_code_t;

  // code that hands the period over to the auto-reload timer
  localparam rate_code_t TMR_CODE = 3'b111;

  // full period, in oscillator cycles, of the fixed-divisor codes
  function automatic logic [11:0] fixed_divisor(input rate_code_t code);
    logic [11:0] d;
    case (code)
      3'd0:    d = 12'd256;
      3'd1:    d = 12'd224;
      3'd2:    d = 12'd192;
      3'd3:    d = 12'd160;
      3'd4:    d = 12'd960;
      3'd5:    d = 12'd120;
      3'd6:    d = 12'd60;
      default: d = 12'd256;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/i2cbr_reload_timer.sv
module i2cbr_reload_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             ovf_o
);

  localparam logic [TMR_W-1:0] TOP = '1;

  logic [TMR_W-1:0] cnt_q;

  assign ovf_o = run_i && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= reload_i;
    end else if (ovf_o) begin
      cnt_q <= reload_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> cnt_q == $past(reload_i)); // R3

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (run_i && !ovf_o) |=> (!run_i || cnt_q == $past(cnt_q) + 1'b1)); // R3

endmodule

// File: rtl/i2cbr_rate_sel.sv
module i2cbr_rate_sel
  import i2cbr_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TMR_HALF = 48
) (
  input  rate_code_t       code_i,
  input  logic             ovf_i,
  output logic [CNT_W-1:0] half_o,
  output logic             step_o
);

  logic [11:0] div;

  always_comb begin
    div = fixed_divisor(code_i);
    if (code_i == TMR_CODE) begin
      half_o = CNT_W'(TMR_HALF);
      step_o = ovf_i;
    end else begin
      half_o = div[CNT_W:1];
      step_o = 1'b1;
    end
  end

  always_comb begin
    AST_HALF_NONZERO: assert (half_o != '0); // R4
  end

endmodule

// File: rtl/i2cbr_phase_gen.sv
module i2cbr_phase_gen
  import i2cbr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  rate_code_t       code_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             step_i,
  output logic             scl_o,
  output logic             tick_o,
  output rate_code_t       act_code_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = step_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      scl_o  <= 1'b1;
      tick_o <= 1'b0;
      if (rst) begin
        act_code_o <= '0;
      end
    end else if (!run_q) begin
      run_q      <= 1'b1;
      cnt_q      <= '0;
      scl_o      <= 1'b1;
      tick_o     <= 1'b0;
      act_code_o <= code_i;
    end else begin
      tick_o <= 1'b0;
      if (wrap) begin
        cnt_q <= '0;
        scl_o <= ~scl_o;
        if (!scl_o) begin
          act_code_o <= code_i;
          tick_o     <= 1'b1;
        end
      end else if (step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (scl_o && !tick_o)); // R5

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(run_q) && run_q && !tick_o) |-> $stable(act_code_o)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q < half_i); // R4

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $rose(scl_o)); // R7

endmodule

// File: rtl/i2c_bitrate_gen.sv
module i2c_bitrate_gen
  import i2cbr_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int TMR_HALF = 48,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [2:0]       rate_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             scl_o,
  output logic             tick_o
);

  logic             ovf;
  logic [CNT_W-1:0] half;
  logic             step;
  rate_code_t       act_code;

  i2cbr_reload_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (en_i),
    .reload_i (reload_i),
    .ovf_o    (ovf)
  );

  i2cbr_rate_sel #(.CNT_W(CNT_W), .TMR_HALF(TMR_HALF)) u_sel (
    .code_i (act_code),
    .ovf_i  (ovf),
    .half_o (half),
    .step_o (step)
  );

  i2cbr_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .code_i     (rate_code_t'(rate_i)),
    .half_i     (half),
    .step_i     (step),
    .scl_o      (scl_o),
    .tick_o     (tick_o),
    .act_code_o (act_code)
  );

endmodule

// File: tb/i2c_bitrate_gen_test.sv
module i2c_bitrate_gen_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [2:0] rate;
  logic [7:0] reload;
  logic       scl;
  logic       tick;

  always #10 clk = ~clk;

  i2c_bitrate_gen uut (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en),
    .rate_i   (rate),
    .reload_i (reload),
    .scl_o    (scl),
    .tick_o   (tick)
  );

  int    checks = 0;
  int    fails  = 0;
  int    pend   = 0;
  bit    arm    = 0;
  int    qp[$];
  int    qh[$];
  string qr[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input int code);
    case (code)
      0: return 256;
      1: return 224;
      2: return 192;
      3: return 160;
      4: return 960;
      5: return 120;
      default: return 60;
    endcase
  endfunction

  // driver side: queue one expected period
  task automatic push(input int per, input string req);
    qp.push_back(per);
    qh.push_back(per / 2);
    qr.push_back(req);
    pend++;
  endtask

  task automatic drain();
    while (pend != 0) @(negedge clk);
  endtask

  task automatic stop_gen();
    @(negedge clk);
    en  = 1'b0;
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: measure period and high time between ticks
  initial begin
    bit base = 0;
    int per  = 0;
    int hi   = 0;
    forever begin
      @(negedge clk);
      if (!arm) begin
        base = 0;
        per  = 0;
        hi   = 0;
      end else begin
        if (tick) begin
          chk(scl == 1'b1, "R7 tick with scl high", int'(scl), 1);
          if (base && qp.size() > 0) begin
            int    ep;
            int    eh;
            string er;
            ep = qp.pop_front();
            eh = qh.pop_front();
            er = qr.pop_front();
            chk(per == ep, er, per, ep);
            chk(hi == eh, "R4 high time", hi, eh);
            pend--;
          end
          base = 1;
          per  = 0;
          hi   = 0;
        end
        per++;
        if (scl) hi++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", pend, 0);
    summary();
    $finish;
  end

  initial begin
    rst    = 1'b1;
    en     = 1'b0;
    rate   = 3'd0;
    reload = 8'd0;
    repeat (4) @(negedge clk);
    chk(scl == 1'b1, "R5 reset scl", int'(scl), 1);
    chk(tick == 1'b0, "R5 reset tick", int'(tick), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R5 idle after reset", int'(scl), 1);

    // R8: first fall after enable, code 3
    begin
      int  n = 0;
      bit  early_tick = 0;
      rate = 3'd3;
      en   = 1'b1;
      while (n < 1000) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (tick) early_tick = 1;
        if (!scl) break;
      end
      chk(n == 81, "R8 first fall edge", n, 81);
      chk(!early_tick, "R7 no tick at enable", int'(early_tick), 0);
    end
    stop_gen();

    // R1 and R2: every fixed code
    for (int c = 0; c < 7; c++) begin
      rate = 3'(c);
      for (int k = 0; k < 3; k++) push(exp_div(c), (c < 4) ? "R1 fixed period" : "R2 fixed period");
      @(negedge clk);
      en  = 1'b1;
      arm = 1'b1;
      drain();
      stop_gen();
    end

    // R3: timer-derived rate for several reload values
    begin
      int rl[4] = '{255, 250, 200, 0};
      int cnt[4] = '{3, 2, 2, 1};
      for (int i = 0; i < 4; i++) begin
        rate   = 3'd7;
        reload = 8'(rl[i]);
        for (int k = 0; k < cnt[i]; k++) push(96 * (256 - rl[i]), "R3 timer period");
        @(negedge clk);
        en  = 1'b1;
        arm = 1'b1;
        drain();
        stop_gen();
      end
    end

    // R6: change the code in the middle of a high phase
    rate = 3'd6;
    push(60, "R6 before change");
    @(negedge clk);
    en  = 1'b1;
    arm = 1'b1;
    drain();
    repeat (10) @(negedge clk);
    rate = 3'd1;
    push(60, "R6 old period kept");
    push(224, "R6 new period");
    push(224, "R6 new period");
    drain();

    // R5: disable in the middle of a period
    repeat (150) @(negedge clk);
    en  = 1'b0;
    arm = 1'b0;
    @(negedge clk);
    chk(scl == 1'b1, "R5 scl after disable", int'(scl), 1);
    chk(tick == 1'b0, "R5 tick after disable", int'(tick), 0);
    begin
      int lows = 0;
      int ticks = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (!scl) lows++;
        if (tick) ticks++;
      end
      chk(lows == 0, "R5 scl held high", lows, 0);
      chk(ticks == 0, "R5 no ticks while off", ticks, 0);
    end

    summary();
    $finish;
  end

endmodule